// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block is a bus-mapped bank of independent up-counting timer channels, six by default, numbered from 1. Each channel has a control word, a tick-source word, a live counter and a compare value. A channel runs in one of three modes. One-shot raises an event once and stops. Repeat raises an event every compare-value ticks. Free-run counts continuously without events. Events latch into a shared pending register that software clears by writing ones. A shared enable mask gates the pending bits onto a single interrupt line.

Two tick-enable inputs act as the clock sources: a fast one and a slow one. Each channel picks one of them and optionally halves its rate. Each channel is controlled by a small state machine with the states `CH_OFF`, `CH_ONCE`, `CH_LOOP` and `CH_FREE`. Its transitions are:
- **arm**: a control write with the enable bit set moves the channel from any state to the state its mode field selects.
- **halt**: a control write with the enable bit clear moves the channel from any state to `CH_OFF`.
- **expire**: a compare match in `CH_ONCE` moves the channel to `CH_OFF`.
- **reload**: a compare match in `CH_LOOP` stays in `CH_LOOP` and zeroes the counter.

Top module: `gp_timer_bank`

## Requirements
- R1: Register offsets are decoded on word-aligned byte addresses. The enable mask is at 0x00 and the pending/acknowledge register is at 0x08. Channel n has control at 16n, tick source at 16n+4, counter at 16n+8 and compare at 16n+12. Read data reflects the addressed register in the same cycle. Written mask, tick-source and compare values read back.
- R2: Control word fields are: bit 0 enable, bit 1 counter clear, bits [5:4] mode. Mode 0 is one-shot, mode 1 is repeat, and mode 3 (and mode 2) is free-run. A read returns the current enable state and the mode, and bit 1 always reads 0.
- R3: A control write with bit 1 set makes the counter read 0 on the following cycle. A control write with bit 1 clear leaves the counter value unchanged.
- R4: The counter increments by one per cycle only while the channel is enabled and its selected tick is high. Tick-source bit 4 picks the tick: 0 for fast, 1 for slow. Tick-source bit 0 set makes the channel advance only on every second selected tick, counted from the last control or tick-source write.
- R5: In repeat mode, a tick that would bring the counter to the compare value sets the channel's pending bit instead and zeroes the counter. The channel stays enabled.
- R6: In one-shot mode, a tick that brings the counter to the compare value sets the pending bit and clears the enable bit. The counter then holds the compare value. A compare value of 3 works.
- R7: In free-run mode, the counter passes the compare value and wraps from all-ones to zero without ever setting a pending bit.
- R8: A control write with the enable bit clear freezes the counter. A later write with the enable bit set and no clear resumes counting from the frozen value.
- R9: Writing to 0x08 clears each pending bit whose data bit (channel n on bit n-1) is 1 and leaves the others unchanged. A match in the same cycle wins over the clear. Reading 0x08 returns the raw pending bits.
- R10: `irq` is high exactly when some pending bit has its enable-mask bit (channel n on bit n-1) set. It rises in the cycle after the pending bit is set.
- R11: Reads of unmapped or misaligned offsets and of channels above the channel count return 0. Writes to them, and writes to a counter register, change nothing.
- R12: After reset, every register reads 0, every channel is off, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
A channel stuck in the wrong state shows up at the counter read within one tick. A frozen counter means a spurious `CH_OFF`. A counter that runs past its compare value means `CH_FREE` was entered instead of `CH_ONCE` or `CH_LOOP`. A bad divider phase offsets the count by one at the second selected tick. A pending bit that is wrongly set or lost is visible at 0x08 and on `irq` in the cycle after the match. The vector walk samples the counter right at the match tick and one tick before it, so an off-by-one in the compare shows at once. A narrow-counter instance brings the wrap point within reach.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_ONCE = 2'd1,
        CH_LOOP = 2'd2,
        CH_FREE = 2'd3
    } ch_state_t;

    localparam logic [1:0] MODE_ONCE = 2'd0;
    localparam logic [1:0] MODE_LOOP = 2'd1;

    localparam int DATA_W = 32;

    // Map the control mode field to the run state it arms.
    function automatic ch_state_t mode_to_state(input logic [1:0] mode);
        case (mode)
            MODE_ONCE: return CH_ONCE;
            MODE_LOOP: return CH_LOOP;
            default:   return CH_FREE;
        endcase
    endfunction

endpackage

// File: rtl/gpt_tick_div.sv
module gpt_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_fast,
    input  logic tick_slow,
    input  logic src_slow,
    input  logic half_rate,
    input  logic run,
    input  logic restart,
    output logic advance
);

    logic sel_tick;
    logic phase_q;

    assign sel_tick = src_slow ? tick_slow : tick_fast;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (restart) begin
            phase_q <= 1'b0;
        end else if (run && sel_tick && half_rate) begin
            phase_q <= ~phase_q;
        end
    end

    assign advance = run && sel_tick && !restart && (!half_rate || phase_q);

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             ctrl_we,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic             ctrl_en,
    input  logic             ctrl_clr,
    input  logic [1:0]       ctrl_mode,
    input  logic             cfg_src,
    input  logic             cfg_div,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [1:0]       mode_o,
    output logic             enabled_o,
    output logic             src_o,
    output logic             div_o,
    output logic             hit_o
);

    ch_state_t        state_q, state_d;
    logic [1:0]       mode_q;
    logic             src_q, div_q;
    logic [CNT_W-1:0] cmp_q, cnt_q, cnt_inc;
    logic             adv, compares, match;

    gpt_tick_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .src_slow  (src_q),
        .half_rate (div_q),
        .run       (state_q != CH_OFF),
        .restart   (ctrl_we | cfg_we),
        .advance   (adv)
    );

    assign cnt_inc  = cnt_q + 1'b1;
    assign compares = (state_q == CH_ONCE) || (state_q == CH_LOOP);
    assign match    = adv && compares && (cnt_inc == cmp_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm / halt on a control write, expire on a one-shot match
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = ctrl_en ? mode_to_state(ctrl_mode) : CH_OFF;
        end else begin
            unique case (state_q)
                CH_OFF:  state_d = CH_OFF;
                CH_ONCE: state_d = match ? CH_OFF : CH_ONCE;
                CH_LOOP: state_d = CH_LOOP;
                CH_FREE: state_d = CH_FREE;
            endcase
        end
    end

    // Configuration and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ONCE;
            src_q  <= 1'b0;
            div_q  <= 1'b0;
            cmp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we) mode_q <= ctrl_mode;
            if (cfg_we) begin
                src_q <= cfg_src;
                div_q <= cfg_div;
            end
            if (cmp_we) cmp_q <= cmp_val;
            if (ctrl_we && ctrl_clr) begin
                cnt_q <= '0;
            end else if (match && state_q == CH_LOOP) begin
                cnt_q <= '0;
            end else if (adv) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // Outputs
    always_comb begin
        count_o   = cnt_q;
        cmp_o     = cmp_q;
        mode_o    = mode_q;
        enabled_o = (state_q != CH_OFF);
        src_o     = src_q;
        div_o     = div_q;
        hit_o     = match;
    end

endmodule

// File: rtl/gpt_pending.sv
module gpt_pending #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq
);

    logic [NUM_CH-1:0] mask_q, pend_q, ack_bits;

    assign ack_bits = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            pend_q <= (pend_q & ~ack_bits) | hit;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;
    assign irq    = |(pend_q & mask_q);

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic             aligned;

    logic [NUM_CH-1:0]            hit_v, en_v, src_v, div_v;
    logic [NUM_CH-1:0][1:0]       mode_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, cmp_v;
    logic [NUM_CH-1:0]            ie_v, pend_v;

    assign blk     = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    gpt_pending #(.NUM_CH(NUM_CH)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_we && aligned && blk == '0 && word == 2'd0),
        .ack_we  (bus_we && aligned && blk == '0 && word == 2'd2),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .hit     (hit_v),
        .mask_o  (ie_v),
        .pend_o  (pend_v),
        .irq     (irq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic here;
        assign here = bus_we && aligned && (blk == BLK_W'(i + 1));

        gpt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .ctrl_we   (here && word == 2'd0),
            .cfg_we    (here && word == 2'd1),
            .cmp_we    (here && word == 2'd3),
            .ctrl_en   (bus_wdata[0]),
            .ctrl_clr  (bus_wdata[1]),
            .ctrl_mode (bus_wdata[5:4]),
            .cfg_src   (bus_wdata[4]),
            .cfg_div   (bus_wdata[0]),
            .cmp_val   (bus_wdata[CNT_W-1:0]),
            .count_o   (cnt_v[i]),
            .cmp_o     (cmp_v[i]),
            .mode_o    (mode_v[i]),
            .enabled_o (en_v[i]),
            .src_o     (src_v[i]),
            .div_o     (div_v[i]),
            .hit_o     (hit_v[i])
        );
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (blk == '0) begin
                if (word == 2'd0) bus_rdata = DATA_W'(ie_v);
                if (word == 2'd2) bus_rdata = DATA_W'(pend_v);
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (blk == BLK_W'(i + 1)) begin
                    unique case (word)
                        2'd0: bus_rdata = {26'd0, mode_v[i], 3'b000, en_v[i]};
                        2'd1: bus_rdata = {27'd0, src_v[i], 3'b000, div_v[i]};
                        2'd2: bus_rdata = DATA_W'(cnt_v[i]);
                        2'd3: bus_rdata = DATA_W'(cmp_v[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         wd_clr,
    input  logic [NUM_CH-1:0]            wd_low,
    input  logic                         irq,
    input  logic [NUM_CH-1:0]            hit_v,
    input  logic [NUM_CH-1:0]            en_v,
    input  logic [NUM_CH-1:0]            pend_v,
    input  logic [NUM_CH-1:0]            ie_v,
    input  logic [NUM_CH-1:0][1:0]       mode_v,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v
);

    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(8);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_v == '0) |-> !irq); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'((i + 1) * 16);
        logic wr_ctrl;
        assign wr_ctrl = bus_we && (bus_addr == CTRL_A);

        AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl && wd_clr) |=> (cnt_v[i] == '0)); // R3

        AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[i] |=> pend_v[i]); // R5

        AST_ONCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_v[i] && mode_v[i] == 2'd0 && !wr_ctrl) |=> !en_v[i]); // R6

        AST_FREE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[i] && mode_v[i][1]) |-> !hit_v[i]); // R7

        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[i] && !wr_ctrl) |=> $stable(cnt_v[i])); // R8

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ACK_A && wd_low[i] && !hit_v[i]) |=> !pend_v[i]); // R9
    end

endmodule

bind gp_timer_bank gpt_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wd_clr   (bus_wdata[1]),
    .wd_low   (bus_wdata[NUM_CH-1:0]),
    .irq      (irq),
    .hit_v    (hit_v),
    .en_v     (en_v),
    .pend_v   (pend_v),
    .ie_v     (ie_v),
    .mode_v   (mode_v),
    .cnt_v    (cnt_v)
);

// File: tb/tb_gp_timer_bank.sv
`timescale 1ns/1ps
module tb_gp_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_n;
    logic        tick_fast = 1'b0, tick_slow = 1'b0;
    logic        irq, irq_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    gp_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    // Narrow counter copy on the same bus, used to reach the wrap point
    gp_timer_bank #(.CNT_W(8)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq_n)
    );

    // op: 0 write, 1 read-compare, 2 fast ticks, 3 slow ticks, 4 irq compare
    localparam int NV = 73;
    localparam logic [46:0] VEC [NV] = '{
        {3'd0, 8'h1C, 32'd5,     4'd1},  // R1 compare ch1
        {3'd1, 8'h1C, 32'd5,     4'd1},  // R1
        {3'd0, 8'h14, 32'h0,     4'd4},  // R4 fast, full rate
        {3'd0, 8'h00, 32'h1,     4'd10}, // R10 mask ch1
        {3'd0, 8'h10, 32'h13,    4'd3},  // R3 repeat+en+clr
        {3'd1, 8'h10, 32'h11,    4'd2},  // R2 clear bit reads 0
        {3'd1, 8'h18, 32'd0,     4'd3},  // R3
        {3'd2, 8'h00, 32'd3,     4'd4},
        {3'd1, 8'h18, 32'd3,     4'd4},  // R4
        {3'd2, 8'h00, 32'd1,     4'd4},
        {3'd1, 8'h08, 32'd0,     4'd9},  // R9 no pending one tick early
        {3'd2, 8'h00, 32'd1,     4'd5},
        {3'd1, 8'h18, 32'd0,     4'd5},  // R5 reload
        {3'd1, 8'h08, 32'd1,     4'd9},  // R9 raw pending
        {3'd4, 8'h00, 32'd1,     4'd10}, // R10
        {3'd0, 8'h08, 32'h1,     4'd9},
        {3'd1, 8'h08, 32'd0,     4'd9},  // R9 ack
        {3'd1, 8'h10, 32'h11,    4'd5},  // R5 still enabled
        {3'd2, 8'h00, 32'd2,     4'd8},
        {3'd0, 8'h10, 32'h10,    4'd8},  // R8 halt
        {3'd2, 8'h00, 32'd3,     4'd8},
        {3'd1, 8'h18, 32'd2,     4'd8},  // R8 frozen
        {3'd1, 8'h10, 32'h10,    4'd2},  // R2
        {3'd0, 8'h2C, 32'd3,     4'd6},
        {3'd0, 8'h24, 32'h0,     4'd6},
        {3'd0, 8'h20, 32'h03,    4'd6},  // one-shot+en+clr
        {3'd2, 8'h00, 32'd3,     4'd6},
        {3'd1, 8'h28, 32'd3,     4'd6},  // R6 holds compare
        {3'd1, 8'h20, 32'h0,     4'd6},  // R6 enable cleared
        {3'd1, 8'h08, 32'd2,     4'd6},  // R6 pending ch2
        {3'd4, 8'h00, 32'd0,     4'd10}, // R10 masked
        {3'd2, 8'h00, 32'd2,     4'd6},
        {3'd1, 8'h28, 32'd3,     4'd6},  // R6 stays stopped
        {3'd0, 8'h00, 32'h3,     4'd10},
        {3'd4, 8'h00, 32'd1,     4'd10}, // R10
        {3'd1, 8'h00, 32'd3,     4'd1},  // R1
        {3'd0, 8'h08, 32'h2,     4'd9},
        {3'd4, 8'h00, 32'd0,     4'd10}, // R10
        {3'd1, 8'h08, 32'd0,     4'd9},  // R9
        {3'd0, 8'h10, 32'h11,    4'd8},  // resume, no clear
        {3'd2, 8'h00, 32'd1,     4'd8},
        {3'd1, 8'h18, 32'd3,     4'd8},  // R8 resumed from 2
        {3'd1, 8'h04, 32'd0,     4'd11}, // R11
        {3'd1, 8'h0C, 32'd0,     4'd11}, // R11
        {3'd1, 8'h70, 32'd0,     4'd11}, // R11 channel 7
        {3'd1, 8'h12, 32'd0,     4'd11}, // R11 misaligned
        {3'd0, 8'h18, 32'h1234,  4'd11},
        {3'd1, 8'h18, 32'd3,     4'd11}, // R11 counter write ignored
        {3'd0, 8'h04, 32'h0,     4'd11},
        {3'd1, 8'h00, 32'd3,     4'd11}, // R11 mask untouched
        {3'd0, 8'h10, 32'h10,    4'd8},
        {3'd0, 8'h34, 32'h0,     4'd7},
        {3'd0, 8'h3C, 32'd2,     4'd7},
        {3'd0, 8'h30, 32'h33,    4'd7},  // free+en+clr
        {3'd1, 8'h30, 32'h31,    4'd2},  // R2
        {3'd2, 8'h00, 32'd5,     4'd7},
        {3'd1, 8'h38, 32'd5,     4'd7},  // R7 passes compare
        {3'd1, 8'h08, 32'd0,     4'd7},  // R7 no event
        {3'd4, 8'h00, 32'd0,     4'd7},
        {3'd0, 8'h30, 32'h31,    4'd3},
        {3'd1, 8'h38, 32'd5,     4'd3},  // R3 no clear keeps count
        {3'd0, 8'h30, 32'h33,    4'd3},
        {3'd1, 8'h38, 32'd0,     4'd3},  // R3
        {3'd0, 8'h4C, 32'd100,   4'd4},
        {3'd0, 8'h44, 32'h11,    4'd4},  // slow, half rate
        {3'd1, 8'h44, 32'h11,    4'd1},  // R1
        {3'd0, 8'h40, 32'h13,    4'd4},
        {3'd2, 8'h00, 32'd4,     4'd4},
        {3'd1, 8'h48, 32'd0,     4'd4},  // R4 fast ticks ignored
        {3'd3, 8'h00, 32'd3,     4'd4},
        {3'd1, 8'h48, 32'd1,     4'd4},  // R4 every second tick
        {3'd3, 8'h00, 32'd1,     4'd4},
        {3'd1, 8'h48, 32'd2,     4'd4}   // R4
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dn);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        dn = rdata_n;
    endtask

    task automatic ticks(input bit slow, input int n);
        @(negedge clk);
        if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
        repeat (n) @(negedge clk);
        tick_slow = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] d, dn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(8'h00, d, dn); check(d, 32'h0, 12);
        rd(8'h08, d, dn); check(d, 32'h0, 12);
        rd(8'h10, d, dn); check(d, 32'h0, 12);
        rd(8'h18, d, dn); check(d, 32'h0, 12);
        check({31'd0, irq}, 32'd0, 12);

        for (int k = 0; k < NV; k++) begin
            logic [2:0]  op;
            logic [7:0]  a;
            logic [31:0] v;
            int          req;
            op  = VEC[k][46:44];
            a   = VEC[k][43:36];
            v   = VEC[k][35:4];
            req = int'(VEC[k][3:0]);
            case (op)
                3'd0: wr(a, v);
                3'd1: begin rd(a, d, dn); check(d, v, req); end
                3'd2: ticks(1'b0, int'(v));
                3'd3: ticks(1'b1, int'(v));
                default: begin @(negedge clk); #1; check({31'd0, irq}, v, req); end
            endcase
        end

        // R7 wrap on the narrow counter
        wr(8'h30, 32'h33);
        ticks(1'b0, 255);
        rd(8'h38, d, dn); check(dn, 32'd255, 7);
        ticks(1'b0, 1);
        rd(8'h38, d, dn); check(dn, 32'd0, 7);
        rd(8'h08, d, dn); check({31'd0, dn[2]}, 32'd0, 7);

        finish_run();
    end

endmodule